// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a SPI master that software drives through a small word-wide register port. A control register selects clock polarity and phase, bit order and an internal loopback path, and it can hold transmission off. A status register reports the fill state of a transmit FIFO and a receive FIFO. A data-out address pushes words into the transmit FIFO and a data-in address pops words from the receive FIFO. A slave-select register has one active-low bit per device.

In normal use, software sets the hold bit and loads a burst of words. It then clears the hold bit, and the shift engine drains the transmit FIFO one word after another. For each word it shifts out, the engine places exactly one captured word into the receive FIFO. The word width and the SCLK divider are fixed by parameters when the block is built. Software cannot change them.

Top module: `spi_host_regs`

## Requirements
- R1: After reset, the status word (address 0x64) reads 0x05. Its bits are: bit0 receive empty, bit1 receive full, bit2 transmit empty, bit3 transmit full, bit4 fault, which always reads 0. After reset the control word (0x60) reads 0x100, `ss_n` is all ones and `sclk` is low.
- R2: The control register holds 10 bits. Bit0 loopback, bit1 enable, bit2 master, bit3 CPOL, bit4 CPHA, bit5 transmit flush, bit6 receive flush, bit7 manual select, bit8 hold, bit9 LSB-first. Any value whose bits 5 and 6 are zero reads back unchanged in bits 9:0. Bits 31:10 read as zero.
- R3: While hold (bit8) is set, `sclk` does not toggle and words written to 0x68 stay in the transmit FIFO.
- R4: Once hold is cleared with enable and master set, the first received word is present 1 + 2·WORD_W·DIV clock cycles after the control write edge. Each transmitted word yields exactly one received word, in order.
- R5: While idle, `sclk` equals CPOL. With CPHA=0, each bit is sampled on the first SCLK edge after the bit is driven. With CPHA=1, it is sampled on the second edge. `mosi` carries the word MSB first by default.
- R6: With bit9 set, the word is sent and captured LSB first.
- R7: With loopback (bit0) set, the received word equals the transmitted word. With loopback clear, the received bits come from `miso`.
- R8: With manual select (bit7) set, `ss_n` equals the value of the select register (0x70). With bit7 clear, `ss_n` is all ones while idle and equals the register while a word is shifting.
- R9: Writing a 1 to bit5 empties the transmit FIFO, and writing a 1 to bit6 empties the receive FIFO. Either bit reads 0 again a cycle later.
- R10: Writes to a full transmit FIFO (DEPTH words) are dropped, and status bit3 is set while the FIFO is full.
- R11: A received word that arrives while the receive FIFO is full is discarded, and status bit1 is set while the FIFO is full.
- R12: If either enable (bit1) or master (bit2) is clear, no word is shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of 0x6C pops at the clock edge) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low device selects |

## Verification
Read data is combinational, so status and register values are checked in the cycle the read is presented. A write takes effect at its own clock edge. The first received word must not be present 2·WORD_W·DIV cycles after the edge that clears hold, and must be present one cycle later. The bench checks both of those cycles. Bit order and sample edges are observed on `mosi`, captured at the SCLK edge that matches CPOL and CPHA. Longer bursts are checked after a fixed window that covers each word's period of 1 + 2·WORD_W·DIV cycles.

// File: rtl/spih_pkg.sv
package spih_pkg;

    localparam logic [7:0] A_CTRL = 8'h60;
    localparam logic [7:0] A_STAT = 8'h64;
    localparam logic [7:0] A_TXD  = 8'h68;
    localparam logic [7:0] A_RXD  = 8'h6C;
    localparam logic [7:0] A_SEL  = 8'h70;

    localparam int CTRL_W = 10;

    // Bit0 is the least significant field (last declared).
    typedef struct packed {
        logic lsb_first;
        logic hold;
        logic manual_ss;
        logic rx_flush;
        logic tx_flush;
        logic cpha;
        logic cpol;
        logic master;
        logic enable;
        logic loop;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = ctrl_t'(10'h100);

    typedef struct packed {
        logic fault;
        logic tx_full;
        logic tx_empty;
        logic rx_full;
        logic rx_empty;
    } stat_t;

    typedef enum logic {SH_IDLE, SH_RUN} sh_state_t;

    function automatic logic [31:0] pack_stat(stat_t s);
        return {27'd0, s};
    endfunction

    function automatic logic [31:0] pack_ctrl(ctrl_t c);
        return {{(32 - CTRL_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/spih_fifo.sv
module spih_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wptr] <= din;
    end

endmodule

// File: rtl/spih_regs.sv
module spih_regs
    import spih_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int NSS    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [WORD_W-1:0] rx_dout,
    input  stat_t             stat,
    output ctrl_t             ctrl,
    output logic [NSS-1:0]    sel,
    output logic              tx_push,
    output logic              rx_pop
);
    logic wr_ctrl, wr_sel;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_sel  = bus_wr && (bus_addr == A_SEL);
    assign tx_push = bus_wr && (bus_addr == A_TXD);
    assign rx_pop  = bus_rd && (bus_addr == A_RXD);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_RST;
            sel  <= '1;
        end else begin
            if (wr_ctrl) begin
                ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            end else begin
                ctrl.tx_flush <= 1'b0;
                ctrl.rx_flush <= 1'b0;
            end
            if (wr_sel) sel <= bus_wdata[NSS-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_CTRL:  bus_rdata = pack_ctrl(ctrl);
                A_STAT:  bus_rdata = pack_stat(stat);
                A_RXD:   bus_rdata = 32'(rx_dout);
                A_SEL:   bus_rdata = 32'(sel);
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/spih_shifter.sv
module spih_shifter
    import spih_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DIV    = 2,
    localparam int EW    = $clog2(2 * WORD_W),
    localparam int DVW   = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              loop,
    input  logic              miso,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_data,
    output logic              busy,
    output logic              sclk,
    output logic              mosi
);
    sh_state_t         state;
    logic [EW-1:0]     ecnt;
    logic [DVW-1:0]    divcnt;
    logic              sclk_q;
    logic [WORD_W-1:0] txs, rxs, rx_next;
    logic              tick, lead, sample_now, shift_now, last, rx_in;

    assign busy   = (state == SH_RUN);
    assign tx_pop = (state == SH_IDLE) && go && !tx_empty;
    assign sclk   = busy ? sclk_q : cpol;
    assign mosi   = lsb_first ? txs[0] : txs[WORD_W-1];
    assign rx_in  = loop ? mosi : miso;

    always_comb begin
        tick       = busy && (divcnt == DVW'(DIV - 1));
        lead       = !ecnt[0];
        // CPHA=0: sample on leading edges; CPHA=1: sample on trailing edges
        sample_now = tick && (lead ^ cpha);
        shift_now  = tick && (cpha ? (lead && (ecnt != '0)) : !lead);
        last       = tick && (ecnt == EW'(2 * WORD_W - 1));
        rx_next    = lsb_first ? {rx_in, rxs[WORD_W-1:1]}
                               : {rxs[WORD_W-2:0], rx_in};
        rx_push    = last;
        rx_data    = sample_now ? rx_next : rxs;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SH_IDLE;
            ecnt   <= '0;
            divcnt <= '0;
            sclk_q <= 1'b0;
            txs    <= '0;
            rxs    <= '0;
        end else begin
            case (state)
                SH_IDLE: begin
                    if (tx_pop) begin
                        txs    <= tx_data;
                        state  <= SH_RUN;
                        ecnt   <= '0;
                        divcnt <= '0;
                        sclk_q <= cpol;
                    end
                end
                SH_RUN: begin
                    if (tick) begin
                        divcnt <= '0;
                        sclk_q <= !sclk_q;
                        ecnt   <= ecnt + EW'(1);
                        if (sample_now) rxs <= rx_next;
                        if (shift_now) txs <= lsb_first ? (txs >> 1) : (txs << 1);
                        if (last) state <= SH_IDLE;
                    end else begin
                        divcnt <= divcnt + DVW'(1);
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
    import spih_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DEPTH  = 4,
    parameter int DIV    = 2,
    parameter int NSS    = 4,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [7:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic           sclk,
    output logic           mosi,
    input  logic           miso,
    output logic [NSS-1:0] ss_n
);
    ctrl_t             ctrl;
    stat_t             stat;
    logic [NSS-1:0]    sel;
    logic              tx_push, rx_pop, tx_pop, rx_push, busy, go;
    logic [WORD_W-1:0] tx_dout, rx_dout, rx_din;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [LW-1:0]     tx_level, rx_level;

    assign go = ctrl.enable && ctrl.master && !ctrl.hold;
    assign ss_n = (ctrl.manual_ss || busy) ? sel : '1;

    always_comb begin
        stat.fault    = 1'b0;
        stat.tx_full  = tx_full;
        stat.tx_empty = tx_empty;
        stat.rx_full  = rx_full;
        stat.rx_empty = rx_empty;
    end

    spih_regs #(.WORD_W(WORD_W), .NSS(NSS)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_dout(rx_dout), .stat(stat), .ctrl(ctrl), .sel(sel),
        .tx_push(tx_push), .rx_pop(rx_pop)
    );

    spih_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .clr(ctrl.tx_flush),
        .push(tx_push), .din(bus_wdata[WORD_W-1:0]),
        .pop(tx_pop), .dout(tx_dout),
        .empty(tx_empty), .full(tx_full), .level(tx_level)
    );

    spih_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .clr(ctrl.rx_flush),
        .push(rx_push), .din(rx_din),
        .pop(rx_pop), .dout(rx_dout),
        .empty(rx_empty), .full(rx_full), .level(rx_level)
    );

    spih_shifter #(.WORD_W(WORD_W), .DIV(DIV)) u_shift (
        .clk(clk), .rst(rst), .go(go),
        .tx_empty(tx_empty), .tx_data(tx_dout), .tx_pop(tx_pop),
        .cpol(ctrl.cpol), .cpha(ctrl.cpha), .lsb_first(ctrl.lsb_first),
        .loop(ctrl.loop), .miso(miso),
        .rx_push(rx_push), .rx_data(rx_din),
        .busy(busy), .sclk(sclk), .mosi(mosi)
    );

endmodule

// File: rtl/spih_checker.sv
module spih_checker #(
    parameter int DEPTH = 4,
    parameter int NSS   = 4,
    parameter int LW    = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           busy,
    input logic           sclk,
    input logic [NSS-1:0] ss_n,
    input logic           cpol,
    input logic           manual_ss,
    input logic           hold,
    input logic           enable,
    input logic           tx_flush,
    input logic [LW-1:0]  tx_level,
    input logic [LW-1:0]  rx_level
);
    // R3: hold keeps the engine idle
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (hold && !busy) |=> !busy);

    // R12: no start without enable
    a_r12_no_enable: assert property (@(posedge clk) disable iff (rst)
        (!enable && !busy) |=> !busy);

    // R5: idle clock level follows CPOL
    a_r5_idle_level: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> (sclk == cpol));

    // R8: automatic select releases all devices while idle
    a_r8_idle_release: assert property (@(posedge clk) disable iff (rst)
        (!manual_ss && !busy) |-> (ss_n == '1));

    // R9: flush empties the transmit FIFO
    a_r9_tx_flush: assert property (@(posedge clk) disable iff (rst)
        tx_flush |=> (tx_level == '0));

    // R10: transmit FIFO never exceeds its depth
    a_r10_tx_bound: assert property (@(posedge clk) disable iff (rst)
        tx_level <= LW'(DEPTH));

    // R11: receive FIFO never exceeds its depth
    a_r11_rx_bound: assert property (@(posedge clk) disable iff (rst)
        rx_level <= LW'(DEPTH));

endmodule

bind spi_host_regs spih_checker #(.DEPTH(DEPTH), .NSS(NSS), .LW(LW)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .sclk(sclk), .ss_n(ss_n),
    .cpol(ctrl.cpol), .manual_ss(ctrl.manual_ss), .hold(ctrl.hold),
    .enable(ctrl.enable), .tx_flush(ctrl.tx_flush),
    .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/tb_spi_host_regs.sv
`timescale 1ns/1ps
module tb_spi_host_regs;
    localparam int WORD_W = 8;
    localparam int DEPTH  = 4;
    localparam int DIV    = 2;
    localparam int NSS    = 4;
    localparam int WORD_CYC = 1 + 2 * WORD_W * DIV;

    logic clk = 0, rst = 1;
    logic bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic sclk, mosi, miso = 1;
    logic [NSS-1:0] ss_n;

    int n_chk = 0, n_fail = 0;
    int pos_cnt = 0;
    logic tb_cpol = 0, tb_cpha = 0;
    logic [31:0] cap_r = 0, cap_f = 0;

    always #5 clk = ~clk;

    spi_host_regs #(.WORD_W(WORD_W), .DEPTH(DEPTH), .DIV(DIV), .NSS(NSS)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    always @(posedge sclk) begin cap_r = {cap_r[30:0], mosi}; pos_cnt++; end
    always @(negedge sclk) cap_f = {cap_f[30:0], mosi};

    function automatic logic [7:0] cap_word();
        return (tb_cpol == tb_cpha) ? cap_r[7:0] : cap_f[7:0];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 0;
    endtask

    task automatic peek(logic [7:0] a, output logic [31:0] d);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 0;
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_rx(string tag);
        logic [31:0] s;
        for (int i = 0; i < 200; i++) begin
            peek(8'h64, s);
            if (!s[0]) return;
            cyc(1);
        end
        chk({tag, " rx timeout"}, 0, 1);
    endtask

    function automatic logic [31:0] cfgval(int mode, bit lp, bit lsb, bit hld);
        return 32'h86 | 32'(lp) | (32'(mode) << 3) | (32'(lsb) << 9) | (32'(hld) << 8);
    endfunction

    task automatic cfg(int mode, bit lp, bit lsb, bit hld);
        tb_cpol = mode[0]; tb_cpha = mode[1];
        wr(8'h60, cfgval(mode, lp, lsb, hld));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        peek(8'h64, v); chk("R1 status", v, 32'h05);
        peek(8'h60, v); chk("R1 ctrl", v, 32'h100);
        chk("R1 ss_n", 32'(ss_n), 32'hF);
        chk("R1 sclk", 32'(sclk), 0);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        wr(8'h60, 32'h39F); peek(8'h60, v); chk("R2 readback", v, 32'h39F);
        wr(8'h60, 32'hFFFF_FD9F); peek(8'h60, v); chk("R2 upper zero", v, 32'h19F);
        wr(8'h60, 32'h100);
    endtask

    task automatic t_hold_release();
        logic [31:0] v; int p0;
        miso = 1;
        cfg(0, 0, 0, 1);
        wr(8'h68, 32'hA5);
        p0 = pos_cnt;
        cyc(50);
        chk("R3 no sclk", 32'(pos_cnt - p0), 0);
        peek(8'h64, v); chk("R3 word kept", v, 32'h01);
        wr(8'h60, cfgval(0, 0, 0, 0));
        cyc(WORD_CYC - 1);
        peek(8'h64, v); chk("R4 not early", 32'(v[0]), 1);
        cyc(1);
        peek(8'h64, v); chk("R4 on time", 32'(v[0]), 0);
        rd(8'h6C, v); chk("R7 miso high", v, 32'hFF);
        chk("R5 mosi msb first", 32'(cap_word()), 32'hA5);
        chk("R5 edge count", 32'(pos_cnt - p0), 8);
        miso = 0;
        wr(8'h68, 32'h3C);
        wait_rx("R7");
        rd(8'h6C, v); chk("R7 miso low", v, 32'h00);
        miso = 1;
    endtask

    task automatic t_modes();
        logic [31:0] v; logic [7:0] w;
        for (int m = 0; m < 4; m++) begin
            w = 8'h5A ^ 8'(m * 8'h11);
            cfg(m, 1, 0, 1);
            cyc(2);
            chk($sformatf("R5 idle level mode%0d", m), 32'(sclk), 32'(tb_cpol));
            wr(8'h68, 32'(w));
            wr(8'h60, cfgval(m, 1, 0, 0));
            wait_rx("R7");
            rd(8'h6C, v); chk($sformatf("R7 loop mode%0d", m), v, 32'(w));
            chk($sformatf("R5 sample edge mode%0d", m), 32'(cap_word()), 32'(w));
        end
    endtask

    task automatic t_lsb();
        logic [31:0] v;
        cfg(0, 1, 1, 1);
        wr(8'h68, 32'h2D);
        wr(8'h60, cfgval(0, 1, 1, 0));
        wait_rx("R6");
        chk("R6 lsb first on wire", 32'(cap_word()), 32'hB4);
        rd(8'h6C, v); chk("R6 lsb first capture", v, 32'h2D);
    endtask

    task automatic t_multi();
        logic [31:0] v;
        cfg(0, 1, 0, 1);
        wr(8'h68, 32'h11); wr(8'h68, 32'h22); wr(8'h68, 32'h33);
        wr(8'h60, cfgval(0, 1, 0, 0));
        cyc(3 * WORD_CYC + 10);
        rd(8'h6C, v); chk("R4 word1", v, 32'h11);
        rd(8'h6C, v); chk("R4 word2", v, 32'h22);
        rd(8'h6C, v); chk("R4 word3", v, 32'h33);
        peek(8'h64, v); chk("R4 one per word", 32'(v[0]), 1);
    endtask

    task automatic t_full();
        logic [31:0] v;
        cfg(0, 1, 0, 1);
        for (int i = 0; i < DEPTH + 2; i++) wr(8'h68, 32'h40 + 32'(i));
        peek(8'h64, v); chk("R10 tx full flag", 32'(v[3]), 1);
        wr(8'h60, cfgval(0, 1, 0, 0));
        cyc((DEPTH + 1) * WORD_CYC + 10);
        peek(8'h64, v); chk("R11 rx full flag", v, 32'h06);
        wr(8'h68, 32'h50);
        cyc(WORD_CYC + 10);
        for (int i = 0; i < DEPTH; i++) begin
            rd(8'h6C, v); chk("R10 R11 kept words", v, 32'h40 + 32'(i));
        end
        peek(8'h64, v); chk("R11 extra dropped", 32'(v[0]), 1);
    endtask

    task automatic t_flush();
        logic [31:0] v;
        cfg(0, 1, 0, 1);
        wr(8'h68, 32'h01); wr(8'h68, 32'h02);
        peek(8'h64, v); chk("R9 tx loaded", 32'(v[2]), 0);
        wr(8'h60, cfgval(0, 1, 0, 1) | 32'h20);
        cyc(2);
        peek(8'h64, v); chk("R9 tx flushed", 32'(v[2]), 1);
        peek(8'h60, v); chk("R9 tx bit clears", v, cfgval(0, 1, 0, 1));
        wr(8'h68, 32'h77);
        wr(8'h60, cfgval(0, 1, 0, 0));
        wait_rx("R9");
        wr(8'h60, cfgval(0, 1, 0, 1) | 32'h40);
        cyc(2);
        peek(8'h64, v); chk("R9 rx flushed", 32'(v[0]), 1);
        peek(8'h60, v); chk("R9 rx bit clears", v, cfgval(0, 1, 0, 1));
    endtask

    task automatic t_select();
        cfg(0, 1, 0, 1);
        wr(8'h70, 32'hE);
        chk("R8 manual", 32'(ss_n), 32'hE);
        wr(8'h60, 32'h107);
        chk("R8 auto idle", 32'(ss_n), 32'hF);
        wr(8'h68, 32'h99);
        wr(8'h60, 32'h007);
        cyc(10);
        chk("R8 auto active", 32'(ss_n), 32'hE);
        wait_rx("R8");
        cyc(2);
        chk("R8 auto release", 32'(ss_n), 32'hF);
        wr(8'h60, cfgval(0, 1, 0, 1) | 32'h40);
    endtask

    task automatic t_enable();
        logic [31:0] v; int p0;
        tb_cpol = 0; tb_cpha = 0;
        wr(8'h60, 32'h005);
        wr(8'h68, 32'h12);
        p0 = pos_cnt;
        cyc(60);
        peek(8'h64, v); chk("R12 no enable", v, 32'h01);
        chk("R12 no edges", 32'(pos_cnt - p0), 0);
        wr(8'h60, 32'h003);
        cyc(60);
        peek(8'h64, v); chk("R12 no master", v, 32'h01);
        wr(8'h60, 32'h007);
        wait_rx("R12");
        rd(8'h6C, v); chk("R12 runs when both set", v, 32'h12);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cyc(3);
        @(negedge clk) rst = 0;
        cyc(1);
        t_reset();
        t_ctrl();
        t_hold_release();
        t_modes();
        t_lsb();
        t_multi();
        t_full();
        t_flush();
        t_select();
        t_enable();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule